// File: doc/BRIEF.md
# Hardware Prefetch Request Queue

This block sits between a prefetch address calculator and the memory-side request path of a cache. The calculator offers candidate block addresses, each with a delay relative to the most recent demand miss. The queue drops candidates that would be wasted: those whose block is already queued, those already outstanding in the miss-status table and, optionally, those already resident in the cache. Surviving candidates are kept oldest first and offered one at a time to a memory-side requester. A bus-request line tells the arbiter that work is waiting.

Demand misses also reach the queue. A miss to a block that is still queued cancels that entry, because the demand fetch makes it redundant. In serial-squash mode a miss also cancels the younger tail entries whose scheduled time is not earlier than the miss, which models a serial calculator that abandons its earlier work. The cache-presence filter runs either when a candidate is inserted or when the head is about to issue. Six event counters report the filtering outcomes.

Top module: `pf_req_queue`

## Requirements
- R1: Addresses are compared at block granularity. The block address is the input address with its low log2(BLK_BYTES) bits cleared, and `iss_addr` always carries a block address.
- R2: A demand miss with `miss_uncached` set has no effect on the queue. A miss with `miss_ifetch` set also has no effect while `cfg_data_only` is 1, but acts normally while `cfg_data_only` is 0.
- R3: A qualifying miss whose block matches a queued entry deletes that entry and increments `cnt_demand_rm`. The remaining entries keep their order.
- R4: With `cfg_serial_squash` = 1, a qualifying miss then removes tail entries one per cycle while the tail's scheduled time is greater than or equal to the miss time. It stops at the first older entry or when the queue is empty, and `cnt_squashed` counts each removal. With the mode at 0 no squash occurs.
- R5: A candidate's scheduled time is the time of the latest qualifying miss (0 after reset) plus `cand_delay`, modulo 2^TIME_W. An entry whose scheduled time equals the miss time is squashed.
- R6: A candidate with `cand_in_mshr` set is discarded. A candidate whose block is already queued is discarded and counted in `cnt_dup`. The queue never holds two entries for one block.
- R7: With `cfg_check_at_insert` = 1, a candidate with `cand_in_cache` set is discarded. With the mode at 0, `cand_in_cache` is ignored.
- R8: A candidate accepted while DEPTH entries are queued first drops the oldest entry and increments `cnt_evicted`, then appends at the tail.
- R9: Entries issue oldest first. With `cfg_check_at_insert` = 0, a head reported cached by `iss_in_cache` is popped when `iss_ready` is high without raising `iss_valid`. An uncached head raises `iss_valid` and is popped and counted in `cnt_issued` when `iss_ready` is high.
- R10: `bus_req` rises in the cycle after an append and falls in the cycle after the queue empties, whether it empties through issue, demand deletion or squash.
- R11: One operation per cycle. `cand_ready` is low while `miss_valid` is high or a squash is running, `miss_ready` is low during a squash, and issue happens only in a cycle with no miss and no candidate offered.
- R12: After reset the queue is empty, `bus_req` and `iss_valid` are 0, both ready outputs are 1, and every counter reads 0.
- R13: `cnt_identified` counts every accepted candidate, whether or not it is filtered out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_data_only | input | 1 | Instruction-fetch misses are ignored when 1 |
| cfg_serial_squash | input | 1 | Enables tail squashing on each qualifying miss |
| cfg_check_at_insert | input | 1 | 1: cache filter at insert; 0: cache filter at issue |
| miss_valid | input | 1 | Demand miss offered |
| miss_ready | output | 1 | Miss accepted this cycle when high |
| miss_addr | input | ADDR_W | Demand miss address |
| miss_time | input | TIME_W | Time stamp of the miss |
| miss_uncached | input | 1 | Miss is to uncacheable space |
| miss_ifetch | input | 1 | Miss is an instruction fetch |
| cand_valid | input | 1 | Candidate offered |
| cand_ready | output | 1 | Candidate accepted this cycle when high |
| cand_addr | input | ADDR_W | Candidate address |
| cand_delay | input | TIME_W | Candidate delay after the latest miss |
| cand_in_cache | input | 1 | Tag lookup result for `cand_addr` |
| cand_in_mshr | input | 1 | Miss-status lookup result for `cand_addr` |
| iss_valid | output | 1 | Head entry offered for issue |
| iss_ready | input | 1 | Requester takes the head |
| iss_addr | output | ADDR_W | Head block address |
| iss_in_cache | input | 1 | Tag lookup result for `iss_addr` |
| bus_req | output | 1 | Queue holds at least one entry |
| cnt_identified | output | CNT_W | Candidates seen |
| cnt_dup | output | CNT_W | Candidates already queued |
| cnt_evicted | output | CNT_W | Entries dropped on overflow |
| cnt_demand_rm | output | CNT_W | Entries removed by demand misses |
| cnt_squashed | output | CNT_W | Entries squashed by misses |
| cnt_issued | output | CNT_W | Prefetches issued |

## Verification
A corrupted entry, a lost deletion or a broken order appears on `iss_addr` at the first issue that reaches the affected slot. The bench therefore drains the queue after every scenario and compares each offered address against an arithmetic model. A wrong scheduled time is invisible until a later squash, where an extra or missing removal changes both the drained sequence and `cnt_squashed`. A miscounted occupancy shows one cycle after the triggering event, as `bus_req` staying high on an empty queue or a candidate being evicted too early.

// File: rtl/pfq_pkg.sv
`timescale 1ns/1ps
package pfq_pkg;
  typedef enum logic {PFQ_IDLE, PFQ_SQUASH} pfq_state_e;

  // event counter slots
  localparam int PFQ_NEV      = 6;
  localparam int EV_IDENT     = 0;
  localparam int EV_DUP       = 1;
  localparam int EV_EVICT     = 2;
  localparam int EV_DEMAND    = 3;
  localparam int EV_SQUASH    = 4;
  localparam int EV_ISSUE     = 5;
endpackage

// File: rtl/pfq_store.sv
`timescale 1ns/1ps
// Ordered entry array: slot 0 is the oldest entry. Valid slots are always
// packed at the low end, so a removal shifts the younger slots down.
module pfq_store #(
  parameter int ADDR_W = 32,
  parameter int TIME_W = 16,
  parameter int DEPTH  = 4,
  parameter int IDX_W  = 2,
  parameter int OCC_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rm_en,
  input  logic [IDX_W-1:0]  rm_idx,
  input  logic              app_en,
  input  logic [ADDR_W-1:0] app_addr,
  input  logic [TIME_W-1:0] app_time,
  input  logic [ADDR_W-1:0] q_miss_blk,
  input  logic [ADDR_W-1:0] q_cand_blk,
  output logic              miss_hit,
  output logic [IDX_W-1:0]  miss_idx,
  output logic              cand_hit,
  output logic [OCC_W-1:0]  count,
  output logic [ADDR_W-1:0] head_addr,
  output logic [TIME_W-1:0] tail_time
);
  logic [DEPTH-1:0]  v_q, v_d;
  logic [ADDR_W-1:0] a_q [DEPTH];
  logic [ADDR_W-1:0] a_d [DEPTH];
  logic [TIME_W-1:0] t_q [DEPTH];
  logic [TIME_W-1:0] t_d [DEPTH];
  logic [DEPTH-1:0]  miss_match, cand_match;
  logic [OCC_W-1:0]  cnt_after_rm;

  always_comb begin
    count = '0;
    for (int i = 0; i < DEPTH; i++) count = count + OCC_W'(v_q[i]);
  end

  assign cnt_after_rm = count - OCC_W'(rm_en);

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      logic              up_v;
      logic [ADDR_W-1:0] up_a;
      logic [TIME_W-1:0] up_t;
      logic              shift_in;
      logic              put_here;

      if (g == DEPTH - 1) begin : g_last
        assign up_v = 1'b0;
        assign up_a = '0;
        assign up_t = '0;
      end else begin : g_mid
        assign up_v = v_q[g+1];
        assign up_a = a_q[g+1];
        assign up_t = t_q[g+1];
      end

      assign shift_in = rm_en && (IDX_W'(g) >= rm_idx);
      assign put_here = app_en && (cnt_after_rm == OCC_W'(g));

      assign v_d[g] = put_here ? 1'b1     : (shift_in ? up_v : v_q[g]);
      assign a_d[g] = put_here ? app_addr : (shift_in ? up_a : a_q[g]);
      assign t_d[g] = put_here ? app_time : (shift_in ? up_t : t_q[g]);

      // parallel block compare against both lookup keys
      assign miss_match[g] = v_q[g] && (a_q[g] == q_miss_blk);
      assign cand_match[g] = v_q[g] && (a_q[g] == q_cand_blk);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q[g] <= 1'b0;
          a_q[g] <= '0;
          t_q[g] <= '0;
        end else begin
          v_q[g] <= v_d[g];
          a_q[g] <= a_d[g];
          t_q[g] <= t_d[g];
        end
      end
    end
  endgenerate

  assign miss_hit  = |miss_match;
  assign cand_hit  = |cand_match;
  assign head_addr = a_q[0];

  always_comb begin
    miss_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) if (miss_match[i]) miss_idx = IDX_W'(i);
  end

  always_comb begin
    tail_time = '0;
    for (int i = 0; i < DEPTH; i++) if (OCC_W'(i + 1) == count) tail_time = t_q[i];
  end

  // R8: valid slots stay packed at the low end after every removal
  a_r8_compact: assert property (@(posedge clk) disable iff (!rst_n)
    ((v_q & (v_q + 1'b1)) == '0));

  // R6: no two valid slots hold the same block
  generate
    for (g = 0; g < DEPTH; g++) begin : g_uq_i
      for (genvar h = g + 1; h < DEPTH; h++) begin : g_uq_j
        a_r6_unique_block: assert property (@(posedge clk) disable iff (!rst_n)
          !(v_q[g] && v_q[h] && (a_q[g] == a_q[h])));
      end
    end
  endgenerate
endmodule

// File: rtl/pfq_ctrl.sv
`timescale 1ns/1ps
// Decides the single operation of each cycle and drives the store.
module pfq_ctrl
  import pfq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TIME_W = 16,
  parameter int DEPTH  = 4,
  parameter int IDX_W  = 2,
  parameter int OCC_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_data_only,
  input  logic               cfg_serial_squash,
  input  logic               cfg_check_at_insert,
  input  logic               miss_valid,
  input  logic [TIME_W-1:0]  miss_time,
  input  logic               miss_uncached,
  input  logic               miss_ifetch,
  input  logic               cand_valid,
  input  logic [ADDR_W-1:0]  cand_blk,
  input  logic [TIME_W-1:0]  cand_delay,
  input  logic               cand_in_cache,
  input  logic               cand_in_mshr,
  input  logic               iss_ready,
  input  logic               iss_in_cache,
  input  logic               miss_hit,
  input  logic [IDX_W-1:0]   miss_idx,
  input  logic               cand_hit,
  input  logic [OCC_W-1:0]   count,
  input  logic [TIME_W-1:0]  tail_time,
  output logic               miss_ready,
  output logic               cand_ready,
  output logic               iss_valid,
  output logic               bus_req,
  output logic               rm_en,
  output logic [IDX_W-1:0]   rm_idx,
  output logic               app_en,
  output logic [ADDR_W-1:0]  app_addr,
  output logic [TIME_W-1:0]  app_time,
  output logic [PFQ_NEV-1:0] ev_inc
);
  function automatic logic [TIME_W-1:0] sched_at(input logic [TIME_W-1:0] base,
                                                 input logic [TIME_W-1:0] dly);
    return base + dly;
  endfunction

  function automatic logic miss_counts(input logic unc, input logic ifetch,
                                       input logic data_only);
    return !unc && !(ifetch && data_only);
  endfunction

  pfq_state_e        st_q, st_d;
  logic [TIME_W-1:0] ref_q;
  logic [OCC_W-1:0]  count_next;

  logic idle, nonempty, full, qual;
  logic miss_take, demand_rm, sq_step, sq_done;
  logic cand_take, cand_drop_cache, cand_drop_mshr, cand_dup, cand_push, evict;
  logic slot_free, head_cached, iss_pop, iss_fire;

  assign idle     = (st_q == PFQ_IDLE);
  assign nonempty = (count != '0);
  assign full     = (count == OCC_W'(DEPTH));
  assign qual     = miss_counts(miss_uncached, miss_ifetch, cfg_data_only);

  // miss path
  assign miss_take = idle && miss_valid;
  assign demand_rm = miss_take && qual && miss_hit;

  // squash walk, one tail entry per cycle
  assign sq_step = !idle && nonempty && (tail_time >= ref_q);
  assign sq_done = !idle && !sq_step;

  // candidate path
  assign cand_take       = idle && !miss_valid && cand_valid;
  assign cand_drop_cache = cfg_check_at_insert && cand_in_cache;
  assign cand_drop_mshr  = !cand_drop_cache && cand_in_mshr;
  assign cand_dup        = !cand_drop_cache && !cand_drop_mshr && cand_hit;
  assign cand_push       = cand_take && !cand_drop_cache && !cand_drop_mshr && !cand_hit;
  assign evict           = cand_push && full;

  // issue path, only in an otherwise quiet cycle
  assign slot_free   = idle && !miss_valid && !cand_valid;
  assign head_cached = !cfg_check_at_insert && iss_in_cache;
  assign iss_pop     = slot_free && nonempty && iss_ready;
  assign iss_fire    = iss_pop && !head_cached;

  assign miss_ready = idle;
  assign cand_ready = idle && !miss_valid;
  assign iss_valid  = slot_free && nonempty && !head_cached;

  assign rm_en    = demand_rm || sq_step || evict || iss_pop;
  assign rm_idx   = demand_rm ? miss_idx :
                    sq_step   ? IDX_W'(count - OCC_W'(1)) : '0;
  assign app_en   = cand_push;
  assign app_addr = cand_blk;
  assign app_time = sched_at(ref_q, cand_delay);

  assign count_next = count - OCC_W'(rm_en) + OCC_W'(app_en);

  always_comb begin
    ev_inc = '0;
    ev_inc[EV_IDENT]  = cand_take;
    ev_inc[EV_DUP]    = cand_take && cand_dup;
    ev_inc[EV_EVICT]  = evict;
    ev_inc[EV_DEMAND] = demand_rm;
    ev_inc[EV_SQUASH] = sq_step;
    ev_inc[EV_ISSUE]  = iss_fire;
  end

  always_comb begin
    st_d = st_q;
    if (miss_take && qual && cfg_serial_squash) st_d = PFQ_SQUASH;
    else if (sq_done)                           st_d = PFQ_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= PFQ_IDLE;
      ref_q   <= '0;
      bus_req <= 1'b0;
    end else begin
      st_q <= st_d;
      if (miss_take && qual) ref_q <= miss_time;
      if (count_next == '0)  bus_req <= 1'b0;
      else if (app_en)       bus_req <= 1'b1;
    end
  end

  // R10: the request line follows the store's occupancy
  a_r10_busreq_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req == (count != '0));

  // R2: a disqualified miss leaves the queue and the state untouched
  a_r2_ignored_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_take && !qual) |=> (count == $past(count)) && (st_q == PFQ_IDLE));

  // R3: a demand deletion shrinks the store by exactly one
  a_r3_demand_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    demand_rm |=> (count == $past(count) - OCC_W'(1)));

  // R4: each squash step removes one entry
  a_r4_squash_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    sq_step |=> (count == $past(count) - OCC_W'(1)));

  // R4: the walk ends on an empty store or an older tail
  a_r4_squash_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_q == PFQ_SQUASH) |-> ((count == '0) || (tail_time < ref_q)));

  // R8: an eviction keeps the store full
  a_r8_evict_full: assert property (@(posedge clk) disable iff (!rst_n)
    evict |=> (count == OCC_W'(DEPTH)));

  // R9: every pop, issued or skipped, removes the head
  a_r9_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    iss_pop |=> (count == $past(count) - OCC_W'(1)));
endmodule

// File: rtl/pfq_event_ctr.sv
`timescale 1ns/1ps
// One wrapping counter per event line.
module pfq_event_ctr #(
  parameter int NEV   = 6,
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NEV-1:0]            inc,
  output logic [NEV-1:0][CNT_W-1:0] cnt
);
  genvar g;
  generate
    for (g = 0; g < NEV; g++) begin : g_ev
      always_ff @(posedge clk) begin
        if (!rst_n)      cnt[g] <= '0;
        else if (inc[g]) cnt[g] <= cnt[g] + CNT_W'(1);
      end

      // R13: a counter moves by one exactly when its event fires
      a_r13_ctr_step: assert property (@(posedge clk) disable iff (!rst_n)
        inc[g] |=> (cnt[g] == $past(cnt[g]) + CNT_W'(1)));
      a_r13_ctr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !inc[g] |=> $stable(cnt[g]));
    end
  endgenerate
endmodule

// File: rtl/pf_req_queue.sv
`timescale 1ns/1ps
module pf_req_queue
  import pfq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int TIME_W    = 16,
  parameter int DEPTH     = 4,
  parameter int BLK_BYTES = 64,
  parameter int CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_data_only,
  input  logic              cfg_serial_squash,
  input  logic              cfg_check_at_insert,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic [TIME_W-1:0] miss_time,
  input  logic              miss_uncached,
  input  logic              miss_ifetch,
  input  logic              cand_valid,
  output logic              cand_ready,
  input  logic [ADDR_W-1:0] cand_addr,
  input  logic [TIME_W-1:0] cand_delay,
  input  logic              cand_in_cache,
  input  logic              cand_in_mshr,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [ADDR_W-1:0] iss_addr,
  input  logic              iss_in_cache,
  output logic              bus_req,
  output logic [CNT_W-1:0]  cnt_identified,
  output logic [CNT_W-1:0]  cnt_dup,
  output logic [CNT_W-1:0]  cnt_evicted,
  output logic [CNT_W-1:0]  cnt_demand_rm,
  output logic [CNT_W-1:0]  cnt_squashed,
  output logic [CNT_W-1:0]  cnt_issued
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(BLK_BYTES - 1);

  function automatic logic [ADDR_W-1:0] to_block(input logic [ADDR_W-1:0] a);
    return a & ~OFS_MASK;
  endfunction

  logic [ADDR_W-1:0] miss_blk, cand_blk, head_addr, app_addr;
  logic [TIME_W-1:0] tail_time, app_time;
  logic              miss_hit, cand_hit, rm_en, app_en;
  logic [IDX_W-1:0]  miss_idx, rm_idx;
  logic [OCC_W-1:0]  count;
  logic [PFQ_NEV-1:0]            ev_inc;
  logic [PFQ_NEV-1:0][CNT_W-1:0] ev_cnt;

  assign miss_blk = to_block(miss_addr);
  assign cand_blk = to_block(cand_addr);
  assign iss_addr = head_addr;

  pfq_store #(
    .ADDR_W(ADDR_W), .TIME_W(TIME_W), .DEPTH(DEPTH), .IDX_W(IDX_W), .OCC_W(OCC_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .rm_en(rm_en), .rm_idx(rm_idx),
    .app_en(app_en), .app_addr(app_addr), .app_time(app_time),
    .q_miss_blk(miss_blk), .q_cand_blk(cand_blk),
    .miss_hit(miss_hit), .miss_idx(miss_idx), .cand_hit(cand_hit),
    .count(count), .head_addr(head_addr), .tail_time(tail_time)
  );

  pfq_ctrl #(
    .ADDR_W(ADDR_W), .TIME_W(TIME_W), .DEPTH(DEPTH), .IDX_W(IDX_W), .OCC_W(OCC_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_data_only(cfg_data_only), .cfg_serial_squash(cfg_serial_squash),
    .cfg_check_at_insert(cfg_check_at_insert),
    .miss_valid(miss_valid), .miss_time(miss_time),
    .miss_uncached(miss_uncached), .miss_ifetch(miss_ifetch),
    .cand_valid(cand_valid), .cand_blk(cand_blk), .cand_delay(cand_delay),
    .cand_in_cache(cand_in_cache), .cand_in_mshr(cand_in_mshr),
    .iss_ready(iss_ready), .iss_in_cache(iss_in_cache),
    .miss_hit(miss_hit), .miss_idx(miss_idx), .cand_hit(cand_hit),
    .count(count), .tail_time(tail_time),
    .miss_ready(miss_ready), .cand_ready(cand_ready),
    .iss_valid(iss_valid), .bus_req(bus_req),
    .rm_en(rm_en), .rm_idx(rm_idx),
    .app_en(app_en), .app_addr(app_addr), .app_time(app_time),
    .ev_inc(ev_inc)
  );

  pfq_event_ctr #(.NEV(PFQ_NEV), .CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .inc(ev_inc), .cnt(ev_cnt)
  );

  assign cnt_identified = ev_cnt[EV_IDENT];
  assign cnt_dup        = ev_cnt[EV_DUP];
  assign cnt_evicted    = ev_cnt[EV_EVICT];
  assign cnt_demand_rm  = ev_cnt[EV_DEMAND];
  assign cnt_squashed   = ev_cnt[EV_SQUASH];
  assign cnt_issued     = ev_cnt[EV_ISSUE];

  // R1: the issued address never carries offset bits
  a_r1_block_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> ((iss_addr & OFS_MASK) == '0));
endmodule

// File: tb/tb_pf_req_queue.sv
`timescale 1ns/1ps
module tb_pf_req_queue;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  bit md_data_only, md_squash, md_chk;
  logic        miss_valid = 0, miss_uncached = 0, miss_ifetch = 0;
  logic [31:0] miss_addr = 0;
  logic [15:0] miss_time = 0;
  logic        cand_valid = 0, cand_in_cache = 0, cand_in_mshr = 0;
  logic [31:0] cand_addr = 0;
  logic [15:0] cand_delay = 0;
  logic        iss_ready = 0, iss_in_cache = 0;
  logic        miss_ready, cand_ready, iss_valid, bus_req;
  logic [31:0] iss_addr;
  logic [15:0] c_ident, c_dup, c_ev, c_dem, c_sq, c_iss;

  pf_req_queue dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_data_only(md_data_only), .cfg_serial_squash(md_squash),
    .cfg_check_at_insert(md_chk),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr),
    .miss_time(miss_time), .miss_uncached(miss_uncached), .miss_ifetch(miss_ifetch),
    .cand_valid(cand_valid), .cand_ready(cand_ready), .cand_addr(cand_addr),
    .cand_delay(cand_delay), .cand_in_cache(cand_in_cache), .cand_in_mshr(cand_in_mshr),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_addr(iss_addr),
    .iss_in_cache(iss_in_cache), .bus_req(bus_req),
    .cnt_identified(c_ident), .cnt_dup(c_dup), .cnt_evicted(c_ev),
    .cnt_demand_rm(c_dem), .cnt_squashed(c_sq), .cnt_issued(c_iss)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 0;

  // reference model of the queue
  int          m_n = 0;
  logic [31:0] m_a [0:7];
  logic [15:0] m_t [0:7];
  logic [15:0] m_ref = 0;
  int e_ident = 0, e_dup = 0, e_ev = 0, e_dem = 0, e_sq = 0, e_iss = 0;

  function automatic logic [31:0] blk(input logic [31:0] a);
    return {a[31:6], 6'b0};
  endfunction

  // bench's own notion of which blocks are resident: block index mod 4 == 3
  function automatic logic is_cached(input logic [31:0] a);
    return (a[7:6] == 2'b11);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic m_remove(input int k);
    for (int i = k; i < m_n - 1; i++) begin
      m_a[i] = m_a[i+1];
      m_t[i] = m_t[i+1];
    end
    m_n--;
  endtask

  task automatic do_miss(input logic [31:0] a, input logic [15:0] t,
                         input logic unc, input logic ifd);
    bit qual;
    @(negedge clk);
    miss_valid = 1; miss_addr = a; miss_time = t;
    miss_uncached = unc; miss_ifetch = ifd;
    #1 chk(cand_ready == 1'b0, "R11 cand_ready with miss", 32'(cand_ready), 0);
    @(posedge clk);
    #1 miss_valid = 0;
    qual = !unc && !(ifd && md_data_only);
    @(negedge clk);
    if (qual && md_squash)
      chk(miss_ready == 1'b0, "R11 miss_ready in squash", 32'(miss_ready), 0);
    while (!miss_ready) @(negedge clk);
    if (qual) begin
      for (int i = 0; i < m_n; i++)
        if (m_a[i] == blk(a)) begin
          m_remove(i);
          e_dem++;
          break;
        end
      m_ref = t;
      if (md_squash)
        while (m_n > 0 && m_t[m_n-1] >= t) begin
          m_n--;
          e_sq++;
        end
    end
  endtask

  task automatic do_cand(input logic [31:0] a, input logic [15:0] d,
                         input logic c, input logic m);
    bit found;
    @(negedge clk);
    cand_valid = 1; cand_addr = a; cand_delay = d;
    cand_in_cache = c; cand_in_mshr = m;
    #1 chk(cand_ready == 1'b1, "R11 cand_ready idle", 32'(cand_ready), 1);
    @(posedge clk);
    #1 cand_valid = 0;
    e_ident++;
    found = 0;
    for (int i = 0; i < m_n; i++) if (m_a[i] == blk(a)) found = 1;
    if (md_chk && c) begin
    end else if (m) begin
    end else if (found) begin
      e_dup++;
    end else begin
      if (m_n == DEPTH) begin
        m_remove(0);
        e_ev++;
      end
      m_a[m_n] = blk(a);
      m_t[m_n] = m_ref + d;
      m_n++;
    end
  endtask

  task automatic issue_one();
    bit skip;
    @(negedge clk);
    iss_ready = 1;
    iss_in_cache = (m_n > 0) ? is_cached(m_a[0]) : 1'b0;
    #1;
    chk(bus_req == (m_n > 0), "R10 bus_req level", 32'(bus_req), 32'(m_n > 0));
    if (m_n > 0) begin
      skip = !md_chk && is_cached(m_a[0]);
      chk(iss_valid == !skip, "R9 iss_valid", 32'(iss_valid), 32'(!skip));
      if (!skip) begin
        chk(iss_addr == m_a[0], "R9 R1 issue order", iss_addr, m_a[0]);
        e_iss++;
      end
      m_remove(0);
    end else begin
      chk(iss_valid == 1'b0, "R9 empty no issue", 32'(iss_valid), 0);
    end
    @(posedge clk);
    #1 iss_ready = 0;
  endtask

  task automatic drain();
    while (m_n > 0) issue_one();
    @(negedge clk);
    chk(bus_req == 1'b0, "R10 bus_req after drain", 32'(bus_req), 0);
    chk(iss_valid == 1'b0, "R9 iss_valid after drain", 32'(iss_valid), 0);
  endtask

  task automatic chk_counters(input string tag);
    chk(c_ident == 16'(e_ident), {"R13 identified ", tag}, 32'(c_ident), 32'(e_ident));
    chk(c_dup   == 16'(e_dup),   {"R6 dup ", tag},         32'(c_dup),   32'(e_dup));
    chk(c_ev    == 16'(e_ev),    {"R8 evicted ", tag},     32'(c_ev),    32'(e_ev));
    chk(c_dem   == 16'(e_dem),   {"R3 demand ", tag},      32'(c_dem),   32'(e_dem));
    chk(c_sq    == 16'(e_sq),    {"R4 squashed ", tag},    32'(c_sq),    32'(e_sq));
    chk(c_iss   == 16'(e_iss),   {"R9 issued ", tag},      32'(c_iss),   32'(e_iss));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      finish_up();
    end
  end

  initial begin
    int seed;
    int base_e;
    md_data_only = 0; md_squash = 0; md_chk = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk(bus_req == 0,    "R12 bus_req",    32'(bus_req),    0);
    chk(iss_valid == 0,  "R12 iss_valid",  32'(iss_valid),  0);
    chk(miss_ready == 1, "R12 miss_ready", 32'(miss_ready), 1);
    chk(cand_ready == 1, "R12 cand_ready", 32'(cand_ready), 1);
    chk_counters("R12 reset");

    // R9 R10: basic order and request line
    do_cand(32'h1000, 0, 0, 0);
    @(negedge clk);
    chk(bus_req == 1, "R10 bus_req after append", 32'(bus_req), 1);
    do_cand(32'h1040, 0, 0, 0);
    do_cand(32'h1080, 0, 0, 0);
    drain();
    chk_counters("basic");

    // R1 R6 R7: filters
    do_cand(32'h2000, 0, 0, 0);
    do_cand(32'h2024, 0, 0, 0);   // same block, R1 duplicate
    do_cand(32'h2040, 0, 0, 1);   // pending miss, R6
    do_cand(32'h2080, 0, 1, 0);   // cached, R7
    drain();
    chk_counters("filters");

    // R8: overflow drops the oldest
    for (int i = 0; i < 5; i++) do_cand(32'h3000 + 32'(i) * 64, 0, 0, 0);
    drain();
    chk_counters("overflow");

    // R2 R3: demand deletion and ignored misses
    do_cand(32'h5000, 0, 0, 0);
    do_cand(32'h5040, 0, 0, 0);
    do_cand(32'h5080, 0, 0, 0);
    do_miss(32'h5044, 16'd10, 1, 0);   // uncached: no effect
    md_data_only = 1;
    do_miss(32'h5044, 16'd11, 0, 1);   // fetch in data-only mode: no effect
    chk_counters("R2 ignored");
    md_data_only = 0;
    do_miss(32'h5044, 16'd12, 0, 1);   // fetch counts now: R3 deletion
    drain();
    chk_counters("demand");

    // R4 R5: serial squash with equal-time boundary
    md_squash = 1;
    do_miss(32'h9000, 16'd100, 0, 0);
    do_cand(32'h6000, 16'd0, 0, 0);
    do_cand(32'h6040, 16'd4, 0, 0);
    do_cand(32'h6080, 16'd8, 0, 0);
    do_miss(32'h9000, 16'd104, 0, 0);
    chk(c_sq == 16'(e_sq), "R5 equal time squashed", 32'(c_sq), 32'(e_sq));
    drain();
    do_cand(32'h6100, 16'd1, 0, 0);
    do_cand(32'h6140, 16'd2, 0, 0);
    do_miss(32'h9000, 16'd0, 0, 0);    // squash everything
    @(negedge clk);
    chk(bus_req == 0, "R10 bus_req after full squash", 32'(bus_req), 0);
    drain();
    chk_counters("squash");
    md_squash = 0;

    // R9 R7: cache check at issue, insert flag ignored
    md_chk = 0;
    do_cand(32'h70C0, 0, 1, 0);
    do_cand(32'h7000, 0, 1, 0);
    do_cand(32'h71C0, 0, 1, 0);
    do_cand(32'h7040, 0, 1, 0);
    drain();
    do_cand(32'h70C0, 0, 0, 0);
    do_cand(32'h71C0, 0, 0, 0);
    drain();
    chk_counters("issue check");

    // near-exhaustive sweep over all mode combinations
    seed = 32'h1234;
    base_e = 200;
    for (int mode = 0; mode < 8; mode++) begin
      md_data_only = mode[0];
      md_squash    = mode[1];
      md_chk       = mode[2];
      for (int op = 0; op < 80; op++) begin
        logic [31:0] a;
        int r;
        seed = seed * 1103515245 + 12345;
        r = (seed >>> 8) & 32'h7fff_ffff;
        a = 32'h4000 + 32'((r >> 4) % 8) * 64 + 32'((r >> 8) % 64);
        case (r % 8)
          0: begin
            base_e += 3;
            do_miss(a, 16'(base_e - (r >> 12) % 8), r[11], r[10]);
          end
          7: issue_one();
          default: do_cand(a, 16'((r >> 13) % 12), is_cached(blk(a)),
                           (blk(a) == 32'h4140));
        endcase
      end
      drain();
      chk_counters("sweep");
    end

    finish_up();
  end
endmodule